// File: doc/BRIEF.md
# Bit-Serial Compare-Exchange Element

This block orders two unsigned operands that stream in one bit per clock, most significant bit first, and streams out the smaller of the two on one output and the larger on the other. The outputs keep the same one-bit-per-cycle timing as the inputs and add no latency.

The ordering is decided while the bits arrive, not by a full-width comparator. Two state flags record the verdict. One flag means "a is the smaller operand" and the other means "b is the smaller operand". Both stay clear while every bit seen so far has been equal. The first bit position where the operands differ sets one of the flags, and that flag then steers a pair of 2:1 multiplexers for the rest of the word.

A start strobe goes with the first bit of each word. It throws away the previous verdict and evaluates that first bit in the same cycle. Several of these elements can be chained into larger sorting networks of serial streams.

Top module: `serial_minmax`

## Requirements
- R1: After reset, with no start strobe given, both flags are clear. While the inputs are equal, minBit equals aBit and maxBit equals bBit. The first differing bit then decides the order.
- R2: For each word, the bits on minBit, gathered MSB first, form the unsigned minimum of the two operands.
- R3: For each word, the bits on maxBit, gathered MSB first, form the unsigned maximum of the two operands.
- R4: In every cycle, the output bits depend only on that cycle's input bits and the stored flags, with no added latency. The pair {minBit, maxBit} is always the pair {aBit, bBit} or its swap.
- R5: Once a bit position has decided the order, later bits of the same word do not change the steering. At most one flag is ever set.
- R6: A start strobe in the same cycle as a word's first bit clears any verdict left from the previous word and evaluates that first bit in that same cycle.
- R7: When the two operands are equal, both output streams carry that same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears both ordering flags |
| wordStart | input | 1 | High together with the first (most significant) bit of a word |
| aBit | input | 1 | Serial bit of operand a |
| bBit | input | 1 | Serial bit of operand b |
| minBit | output | 1 | Serial bit of the smaller operand |
| maxBit | output | 1 | Serial bit of the larger operand |

## Verification
The element has no parameters, so the bench picks the word length itself and runs 8-bit words. That length is short enough for the run to cover words that differ only in the least significant bit, all-zero and all-ones words, equal operands, and back-to-back words whose order flips from one word to the next. The bench also checks the reset state by streaming bits before any start strobe.

// File: rtl/serial_minmax_pkg.sv
package serial_minmax_pkg;
  // Strobes from the ordering control to the datapath
  typedef struct packed {
    logic swapSel; // 1: b goes to min, a goes to max
  } steer_t;
endpackage

// File: rtl/serial_minmax_ctrl.sv
module serial_minmax_ctrl
  import serial_minmax_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wordStart,
  input  logic   aBit,
  input  logic   bBit,
  output steer_t steer
);
  logic aLessQ, bLessQ;
  logic priorA, priorB;
  logic decideA, decideB;

  always_comb begin
    // A start strobe discards the old verdict before this bit is judged
    priorA  = wordStart ? 1'b0 : aLessQ;
    priorB  = wordStart ? 1'b0 : bLessQ;
    decideA = priorA | (~priorB & ~aBit &  bBit);
    decideB = priorB | (~priorA &  aBit & ~bBit);
    steer.swapSel = decideB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLessQ <= 1'b0;
      bLessQ <= 1'b0;
    end else begin
      aLessQ <= decideA;
      bLessQ <= decideB;
    end
  end

  // R5: the two verdicts exclude each other
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aLessQ, bLessQ}));

  // R5: a verdict held from earlier bits overrides the current bits
  assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (aLessQ && !wordStart) |-> !steer.swapSel);
  assert_hold_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bLessQ && !wordStart) |-> steer.swapSel);

  // R6: a start strobe on an equal bit leaves the flags clear
  assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordStart && (aBit == bBit)) |=> (!aLessQ && !bLessQ));

  // R6: a start strobe with a>b on the first bit swaps in that same cycle
  assert_start_decides_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordStart && aBit && !bBit) |-> steer.swapSel);
endmodule

// File: rtl/serial_minmax_dp.sv
module serial_minmax_dp
  import serial_minmax_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  steer_t steer,
  input  logic   aBit,
  input  logic   bBit,
  output logic   minBit,
  output logic   maxBit
);
  always_comb begin
    minBit = steer.swapSel ? bBit : aBit;
    maxBit = steer.swapSel ? aBit : bBit;
  end

  // R4: the outputs are a permutation of this cycle's inputs
  assert_output_permutation_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((minBit ^ maxBit) == (aBit ^ bBit)) && ((minBit & maxBit) == (aBit & bBit)));
endmodule

// File: rtl/serial_minmax.sv
module serial_minmax
  import serial_minmax_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wordStart,
  input  logic aBit,
  input  logic bBit,
  output logic minBit,
  output logic maxBit
);
  steer_t steer;

  serial_minmax_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordStart(wordStart),
    .aBit(aBit), .bBit(bBit), .steer(steer)
  );

  serial_minmax_dp u_dp (
    .clk(clk), .rstN(rstN), .steer(steer),
    .aBit(aBit), .bBit(bBit), .minBit(minBit), .maxBit(maxBit)
  );
endmodule

// File: tb/serial_minmax_bench.sv
module serial_minmax_bench;
  localparam int WordBits = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wordStart = 1'b0;
  logic aBit = 1'b0;
  logic bBit = 1'b0;
  logic minBit, maxBit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  serial_minmax u_serial_minmax (
    .clk(clk), .rstN(rstN), .wordStart(wordStart),
    .aBit(aBit), .bBit(bBit), .minBit(minBit), .maxBit(maxBit)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle with the inputs set at the falling edge; sample 5 ns later
  task automatic drive(bit st, bit a, bit b);
    @(negedge clk);
    wordStart = st; aBit = a; bBit = b;
    #5;
  endtask

  // Stream one word of each operand and compare every bit and the gathered words
  task automatic sendWord(int aw, int bw);
    int expMin = (aw < bw) ? aw : bw;
    int expMax = (aw < bw) ? bw : aw;
    int gotMin = 0;
    int gotMax = 0;
    for (int i = WordBits - 1; i >= 0; i--) begin
      drive(i == WordBits - 1, aw[i], bw[i]);
      check("R4 min bit same cycle", minBit, expMin[i]);
      check("R4 max bit same cycle", maxBit, expMax[i]);
      gotMin = (gotMin << 1) | int'(minBit);
      gotMax = (gotMax << 1) | int'(maxBit);
    end
    check("R2 min word", gotMin, expMin);
    check("R3 max word", gotMax, expMax);
    if (aw == bw) check("R7 equal words", gotMin, gotMax);
  endtask

  initial begin
    // Reset state
    #35;
    rstN = 1'b1;
    // R1: equal bits before any start strobe pass straight through
    drive(0, 1, 1);
    check("R1 equal min", minBit, 1);
    check("R1 equal max", maxBit, 1);
    // R1: first difference a<b keeps a on min
    drive(0, 0, 1);
    check("R1 a<b min", minBit, 0);
    check("R1 a<b max", maxBit, 1);
    // R5: a later reversed bit does not flip the steering
    drive(0, 1, 0);
    check("R5 held min", minBit, 1);
    check("R5 held max", maxBit, 0);

    // Main function and boundaries
    sendWord(8'h35, 8'hA2);
    sendWord(8'hA2, 8'h35);
    sendWord(8'h00, 8'hFF);
    sendWord(8'hFF, 8'hFF); // R7
    sendWord(8'h00, 8'h00); // R7
    sendWord(8'h80, 8'h81); // differ in LSB only
    sendWord(8'h81, 8'h80);
    // R6: previous word left "b smaller"; new first bit a<b must swap back at once
    sendWord(8'hF0, 8'h0F);
    drive(1, 0, 1);
    check("R6 first bit min", minBit, 0);
    check("R6 first bit max", maxBit, 1);
    for (int i = 0; i < WordBits - 1; i++) drive(0, 1, 0);
    check("R6 rest min", minBit, 1);
    check("R6 rest max", maxBit, 0);
    // R6: stale verdict cleared on an equal first bit
    sendWord(8'hC0, 8'h3F);
    sendWord(8'h5A, 8'h5B);
    for (int n = 0; n < 200; n++) begin
      int aw = int'($urandom_range(0, 255));
      int bw = (n % 5 == 0) ? aw : int'($urandom_range(0, 255));
      sendWord(aw, bw);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule